// File: doc/BRIEF.md
# Non-Coherent Private Data Cache with Global Bypass

This block is a small private data cache that sits between one accelerator core's load/store port and a shared global cache. It holds no coherence state and does no snooping. Ordinary loads and stores are served from a direct-mapped, write-back, write-allocate array. Requests flagged as global skip the local array and go to the global side one word at a time. Atomic read-modify-write requests are always passed to the global side unchanged, and the global side performs them.

Software keeps shared data correct at phase boundaries with two bulk commands. A flush writes every dirty line back and answers only after the last write has been acknowledged, so a barrier may follow it. An invalidate drops every local line so that later input reads fetch fresh data. An invalidate is refused with an error if any line is still dirty. Both sides use valid/ready handshakes. Only one global request is outstanding at a time, and the core is stalled from the moment its request is accepted until its response arrives.

Addresses are word addresses. Bits [1:0] select the word within a four-word line, bits [5:2] select one of sixteen lines, and the remaining upper bits form the tag. Core opcodes: 0 load, 1 store, 2 atomic, 3 flush, 4 invalidate. Global opcodes: 0 read, 1 write, 2 atomic.

Top module: `l1nc_cache`

## Requirements
- R1: When reset is released, core_req_ready is 1, core_rsp_valid is 0 and glb_req_valid is 0, and every line is invalid, so the next local load misses.
- R2: A local load (op 0, global 0) that misses issues four global reads (op 0) covering the whole line and returns the addressed word. A later local load that hits causes no global traffic.
- R3: A local store (op 1, global 0) that hits updates the local copy with no global traffic. A store that misses first fills the line. A dirty line that is evicted is written back with four global writes (op 1) before the new line is fetched.
- R4: A global load (op 0, global 1) is always served by one global read of its own address and allocates no line. If the matching local line is dirty, that line is written back first, and the read then returns the written-back data.
- R5: A global store (op 1, global 1) is written through with one global write and leaves no local copy. A dirty matching line is written back first, and a matching line is dropped, so a later local load fetches the line again.
- R6: An atomic request (op 2) is forwarded as one global atomic (op 2) carrying the core's address and data, and the global response data is returned to the core. A dirty matching line is written back first and then dropped.
- R7: A flush (op 3) writes back exactly the dirty lines, four words each, and responds only after the last write is acknowledged. Afterwards no line is dirty, and a second flush causes no global traffic.
- R8: An invalidate (op 4) issued when no line is dirty clears every valid bit in one step and responds with core_rsp_err 0. Every later local access misses.
- R9: An invalidate issued while any line is dirty responds with core_rsp_err 1 and leaves every line unchanged. A later local hit still returns the local data with no global traffic.
- R10: At most one global request is outstanding. While glb_req_valid is high and glb_req_ready is low, the opcode, address and data stay stable.
- R11: core_req_ready stays low from the acceptance of a core request until its response, including throughout a flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_req_valid | input | 1 | Core request valid |
| core_req_ready | output | 1 | Cache can accept a core request |
| core_req_op | input | 3 | Core opcode (0 load, 1 store, 2 atomic, 3 flush, 4 invalidate) |
| core_req_global | input | 1 | Bypass the local array for a load or store |
| core_req_addr | input | ADDR_W | Word address |
| core_req_wdata | input | DATA_W | Store or atomic operand |
| core_rsp_valid | output | 1 | Single-cycle response strobe |
| core_rsp_rdata | output | DATA_W | Load or atomic result |
| core_rsp_err | output | 1 | Invalidate refused because dirty lines exist |
| glb_req_valid | output | 1 | Global request valid |
| glb_req_ready | input | 1 | Global side accepts the request |
| glb_req_op | output | 2 | Global opcode (0 read, 1 write, 2 atomic) |
| glb_req_addr | output | ADDR_W | Global word address |
| glb_req_wdata | output | DATA_W | Global write data or atomic operand |
| glb_rsp_valid | input | 1 | Global response strobe |
| glb_rsp_rdata | input | DATA_W | Global read or atomic result |

## Verification
The assertions watch the handshakes on every cycle: the stability of a stalled global request, the single outstanding request, the core stall until the response arrives, the forwarding of atomics with unchanged address and operand, the single-address read of a global load, the clean state once a flush answers, and the error flag of an invalidate matching the dirty state. Whether data really survives write-back, whether a global store drops the local copy, whether eviction picks the right victim, and whether an invalidate leaves fresh reads behind can only be shown by the bench's scenarios. The bench compares returned data and per-request counts of global reads, writes and atomics against a reference memory.

// File: rtl/l1nc_pkg.sv
package l1nc_pkg;
  typedef enum logic [2:0] {
    OP_LOAD   = 3'd0,
    OP_STORE  = 3'd1,
    OP_ATOMIC = 3'd2,
    OP_FLUSH  = 3'd3,
    OP_INVAL  = 3'd4
  } core_op_e;

  typedef enum logic [1:0] {
    G_READ   = 2'd0,
    G_WRITE  = 2'd1,
    G_ATOMIC = 2'd2
  } glb_op_e;

  // where to continue once a dirty line has been written back
  typedef enum logic [1:0] {
    RET_FILL  = 2'd0,
    RET_GLOB  = 2'd1,
    RET_FLUSH = 2'd2
  } wb_ret_e;

  typedef enum logic [3:0] {
    S_IDLE, S_CHECK, S_HITRD, S_WBRD, S_WBLD, S_WBWAIT,
    S_FWAIT, S_GWAIT, S_FLSCAN, S_FLNEXT
  } state_e;
endpackage

// File: rtl/l1nc_dataram.sv
module l1nc_dataram #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 32,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic [AW-1:0]     addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  logic [DATA_W-1:0] mem [DEPTH];

  // single port, registered read: maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    q <= mem[addr];
  end
endmodule

// File: rtl/l1nc_tagstore.sv
module l1nc_tagstore #(
  parameter int LINES = 16,
  parameter int TAG_W = 10,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] idx,
  input  logic             fill,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             set_dirty,
  input  logic             clr_dirty,
  input  logic             drop,
  input  logic             drop_all,
  output logic             valid_o,
  output logic             dirty_o,
  output logic [TAG_W-1:0] tag_o,
  output logic             any_dirty_o
);
  logic [LINES-1:0] vld, drt;
  logic [TAG_W-1:0] tags [LINES];

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= '0;
      drt <= '0;
    end else begin
      if (drop_all) vld <= '0;
      if (fill) begin
        vld[idx] <= 1'b1;
        drt[idx] <= 1'b0;
      end
      if (set_dirty) drt[idx] <= 1'b1;
      if (clr_dirty) drt[idx] <= 1'b0;
      if (drop)      vld[idx] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (fill) tags[idx] <= fill_tag;
  end

  assign valid_o     = vld[idx];
  assign dirty_o     = drt[idx];
  assign tag_o       = tags[idx];
  assign any_dirty_o = |drt;
endmodule

// File: rtl/l1nc_ctrl.sv
module l1nc_ctrl
  import l1nc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int LINES  = 16,
  parameter int WORDS  = 4,
  localparam int IDX_W = $clog2(LINES),
  localparam int OFF_W = $clog2(WORDS),
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   core_req_valid,
  output logic                   core_req_ready,
  input  logic [2:0]             core_req_op,
  input  logic                   core_req_global,
  input  logic [ADDR_W-1:0]      core_req_addr,
  input  logic [DATA_W-1:0]      core_req_wdata,
  output logic                   core_rsp_valid,
  output logic [DATA_W-1:0]      core_rsp_rdata,
  output logic                   core_rsp_err,
  output logic                   glb_req_valid,
  input  logic                   glb_req_ready,
  output logic [1:0]             glb_req_op,
  output logic [ADDR_W-1:0]      glb_req_addr,
  output logic [DATA_W-1:0]      glb_req_wdata,
  input  logic                   glb_rsp_valid,
  input  logic [DATA_W-1:0]      glb_rsp_rdata,
  output logic [IDX_W-1:0]       ts_idx,
  input  logic                   ts_valid,
  input  logic                   ts_dirty,
  input  logic [TAG_W-1:0]       ts_tag,
  input  logic                   ts_any_dirty,
  output logic                   ts_fill,
  output logic [TAG_W-1:0]       ts_fill_tag,
  output logic                   ts_set_dirty,
  output logic                   ts_clr_dirty,
  output logic                   ts_drop,
  output logic                   ts_drop_all,
  output logic [IDX_W+OFF_W-1:0] ram_addr,
  output logic                   ram_we,
  output logic [DATA_W-1:0]      ram_wdata,
  input  logic [DATA_W-1:0]      ram_q
);
  localparam logic [OFF_W-1:0] LAST_W = OFF_W'(WORDS - 1);
  localparam logic [IDX_W-1:0] LAST_L = IDX_W'(LINES - 1);

  state_e            state;
  wb_ret_e           ret_q;
  logic [2:0]        r_op;
  logic              r_glob;
  logic [ADDR_W-1:0] r_addr;
  logic [DATA_W-1:0] r_wdata;
  logic [IDX_W-1:0]  line_q;
  logic [OFF_W-1:0]  cnt_q;
  logic              rsp_v_q, rsp_e_q;
  logic [DATA_W-1:0] rsp_d_q;
  logic              g_v_q;
  logic [1:0]        g_op_q;
  logic [ADDR_W-1:0] g_a_q;
  logic [DATA_W-1:0] g_d_q;

  logic [TAG_W-1:0] r_tag;
  logic [OFF_W-1:0] r_off;
  logic             hit, bypass, st_hit, last_rsp;
  logic [1:0]       byp_op;

  assign r_tag    = r_addr[ADDR_W-1 -: TAG_W];
  assign r_off    = r_addr[OFF_W-1:0];
  assign hit      = ts_valid && (ts_tag == r_tag);
  assign bypass   = r_glob || (r_op == OP_ATOMIC);
  assign st_hit   = !bypass && hit && (r_op == OP_STORE);
  assign last_rsp = glb_rsp_valid && (cnt_q == LAST_W);
  assign byp_op   = (r_op == OP_ATOMIC) ? G_ATOMIC :
                    (r_op == OP_STORE)  ? G_WRITE  : G_READ;

  assign ts_idx       = line_q;
  assign ts_fill_tag  = r_tag;
  assign ts_fill      = (state == S_FWAIT) && last_rsp;
  assign ts_set_dirty = (state == S_CHECK) && st_hit;
  assign ts_clr_dirty = (state == S_WBWAIT) && last_rsp;
  assign ts_drop      = (state == S_GWAIT) && glb_rsp_valid && hit &&
                        (r_op == OP_STORE || r_op == OP_ATOMIC);
  assign ts_drop_all  = (state == S_CHECK) && (r_op == OP_INVAL) && !ts_any_dirty;

  assign ram_addr  = (state == S_WBRD || state == S_FWAIT) ? {line_q, cnt_q} : {line_q, r_off};
  assign ram_we    = ts_set_dirty || ((state == S_FWAIT) && glb_rsp_valid);
  assign ram_wdata = (state == S_FWAIT) ? glb_rsp_rdata : r_wdata;

  assign core_req_ready = (state == S_IDLE);
  assign core_rsp_valid = rsp_v_q;
  assign core_rsp_rdata = rsp_d_q;
  assign core_rsp_err   = rsp_e_q;
  assign glb_req_valid  = g_v_q;
  assign glb_req_op     = g_op_q;
  assign glb_req_addr   = g_a_q;
  assign glb_req_wdata  = g_d_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      ret_q   <= RET_FILL;
      r_op    <= '0;
      r_glob  <= 1'b0;
      r_addr  <= '0;
      r_wdata <= '0;
      line_q  <= '0;
      cnt_q   <= '0;
      rsp_v_q <= 1'b0;
      rsp_e_q <= 1'b0;
      rsp_d_q <= '0;
      g_v_q   <= 1'b0;
      g_op_q  <= G_READ;
      g_a_q   <= '0;
      g_d_q   <= '0;
    end else begin
      rsp_v_q <= 1'b0;
      if (g_v_q && glb_req_ready) g_v_q <= 1'b0;
      unique case (state)
        S_IDLE: if (core_req_valid) begin
          r_op    <= core_req_op;
          r_glob  <= core_req_global;
          r_addr  <= core_req_addr;
          r_wdata <= core_req_wdata;
          line_q  <= core_req_addr[OFF_W +: IDX_W];
          state   <= S_CHECK;
        end
        S_CHECK: begin
          cnt_q <= '0;
          if (r_op == OP_FLUSH) begin
            line_q <= '0;
            state  <= S_FLSCAN;
          end else if (r_op == OP_INVAL) begin
            rsp_v_q <= 1'b1;
            rsp_e_q <= ts_any_dirty;
            rsp_d_q <= '0;
            state   <= S_IDLE;
          end else if (bypass) begin
            if (hit && ts_dirty) begin
              ret_q <= RET_GLOB;
              state <= S_WBRD;
            end else begin
              g_v_q <= 1'b1; g_op_q <= byp_op; g_a_q <= r_addr; g_d_q <= r_wdata;
              state <= S_GWAIT;
            end
          end else if (hit) begin
            if (r_op == OP_STORE) begin
              rsp_v_q <= 1'b1; rsp_e_q <= 1'b0; rsp_d_q <= '0;
              state   <= S_IDLE;
            end else begin
              state <= S_HITRD;
            end
          end else if (ts_valid && ts_dirty) begin
            ret_q <= RET_FILL;
            state <= S_WBRD;
          end else begin
            g_v_q <= 1'b1; g_op_q <= G_READ; g_a_q <= {r_tag, line_q, {OFF_W{1'b0}}};
            state <= S_FWAIT;
          end
        end
        S_HITRD: begin
          rsp_v_q <= 1'b1; rsp_e_q <= 1'b0; rsp_d_q <= ram_q;
          state   <= S_IDLE;
        end
        S_WBRD: state <= S_WBLD;
        S_WBLD: begin
          g_v_q <= 1'b1; g_op_q <= G_WRITE; g_a_q <= {ts_tag, line_q, cnt_q}; g_d_q <= ram_q;
          state <= S_WBWAIT;
        end
        S_WBWAIT: if (glb_rsp_valid) begin
          if (cnt_q == LAST_W) begin
            cnt_q <= '0;
            unique case (ret_q)
              RET_FILL: begin
                g_v_q <= 1'b1; g_op_q <= G_READ; g_a_q <= {r_tag, line_q, {OFF_W{1'b0}}};
                state <= S_FWAIT;
              end
              RET_GLOB: begin
                g_v_q <= 1'b1; g_op_q <= byp_op; g_a_q <= r_addr; g_d_q <= r_wdata;
                state <= S_GWAIT;
              end
              default: state <= S_FLNEXT;
            endcase
          end else begin
            cnt_q <= cnt_q + 1'b1;
            state <= S_WBRD;
          end
        end
        S_FWAIT: if (glb_rsp_valid) begin
          if (cnt_q == LAST_W) begin
            state <= S_CHECK;
          end else begin
            cnt_q <= cnt_q + 1'b1;
            g_v_q <= 1'b1; g_op_q <= G_READ; g_a_q <= {r_tag, line_q, cnt_q + 1'b1};
          end
        end
        S_GWAIT: if (glb_rsp_valid) begin
          rsp_v_q <= 1'b1; rsp_e_q <= 1'b0; rsp_d_q <= glb_rsp_rdata;
          state   <= S_IDLE;
        end
        S_FLSCAN: begin
          cnt_q <= '0;
          if (ts_valid && ts_dirty) begin
            ret_q <= RET_FLUSH;
            state <= S_WBRD;
          end else begin
            state <= S_FLNEXT;
          end
        end
        S_FLNEXT: begin
          if (line_q == LAST_L) begin
            rsp_v_q <= 1'b1; rsp_e_q <= 1'b0; rsp_d_q <= '0;
            state   <= S_IDLE;
          end else begin
            line_q <= line_q + 1'b1;
            state  <= S_FLSCAN;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/l1nc_cache.sv
module l1nc_cache #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int LINES  = 16,
  parameter int WORDS  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              core_req_valid,
  output logic              core_req_ready,
  input  logic [2:0]        core_req_op,
  input  logic              core_req_global,
  input  logic [ADDR_W-1:0] core_req_addr,
  input  logic [DATA_W-1:0] core_req_wdata,
  output logic              core_rsp_valid,
  output logic [DATA_W-1:0] core_rsp_rdata,
  output logic              core_rsp_err,
  output logic              glb_req_valid,
  input  logic              glb_req_ready,
  output logic [1:0]        glb_req_op,
  output logic [ADDR_W-1:0] glb_req_addr,
  output logic [DATA_W-1:0] glb_req_wdata,
  input  logic              glb_rsp_valid,
  input  logic [DATA_W-1:0] glb_rsp_rdata
);
  localparam int IDX_W = $clog2(LINES);
  localparam int OFF_W = $clog2(WORDS);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

  logic [IDX_W-1:0]       ts_idx;
  logic                   ts_valid, ts_dirty, ts_any_dirty;
  logic [TAG_W-1:0]       ts_tag, ts_fill_tag;
  logic                   ts_fill, ts_set_dirty, ts_clr_dirty, ts_drop, ts_drop_all;
  logic [IDX_W+OFF_W-1:0] ram_addr;
  logic                   ram_we;
  logic [DATA_W-1:0]      ram_wdata, ram_q;

  l1nc_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES), .WORDS(WORDS)) u_ctrl (
    .clk, .rst,
    .core_req_valid, .core_req_ready, .core_req_op, .core_req_global,
    .core_req_addr, .core_req_wdata,
    .core_rsp_valid, .core_rsp_rdata, .core_rsp_err,
    .glb_req_valid, .glb_req_ready, .glb_req_op, .glb_req_addr, .glb_req_wdata,
    .glb_rsp_valid, .glb_rsp_rdata,
    .ts_idx, .ts_valid, .ts_dirty, .ts_tag, .ts_any_dirty,
    .ts_fill, .ts_fill_tag, .ts_set_dirty, .ts_clr_dirty, .ts_drop, .ts_drop_all,
    .ram_addr, .ram_we, .ram_wdata, .ram_q
  );

  l1nc_tagstore #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
    .clk, .rst,
    .idx(ts_idx), .fill(ts_fill), .fill_tag(ts_fill_tag),
    .set_dirty(ts_set_dirty), .clr_dirty(ts_clr_dirty),
    .drop(ts_drop), .drop_all(ts_drop_all),
    .valid_o(ts_valid), .dirty_o(ts_dirty), .tag_o(ts_tag), .any_dirty_o(ts_any_dirty)
  );

  l1nc_dataram #(.DEPTH(LINES * WORDS), .DATA_W(DATA_W)) u_ram (
    .clk, .addr(ram_addr), .we(ram_we), .wdata(ram_wdata), .q(ram_q)
  );
endmodule

// File: rtl/l1nc_cache_chk.sv
module l1nc_cache_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              core_req_valid,
  input logic              core_req_ready,
  input logic [2:0]        core_req_op,
  input logic              core_req_global,
  input logic [ADDR_W-1:0] core_req_addr,
  input logic [DATA_W-1:0] core_req_wdata,
  input logic              core_rsp_valid,
  input logic              core_rsp_err,
  input logic              glb_req_valid,
  input logic              glb_req_ready,
  input logic [1:0]        glb_req_op,
  input logic [ADDR_W-1:0] glb_req_addr,
  input logic [DATA_W-1:0] glb_req_wdata,
  input logic              glb_rsp_valid,
  input logic              any_dirty
);
  logic [2:0]        pend_op;
  logic              pend_glob, busy_q, out_q;
  logic [ADDR_W-1:0] pend_addr;
  logic [DATA_W-1:0] pend_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_op <= '0; pend_glob <= 1'b0; pend_addr <= '0; pend_wdata <= '0;
      busy_q <= 1'b0; out_q <= 1'b0;
    end else begin
      if (core_req_valid && core_req_ready) begin
        pend_op <= core_req_op; pend_glob <= core_req_global;
        pend_addr <= core_req_addr; pend_wdata <= core_req_wdata;
        busy_q <= 1'b1;
      end else if (core_rsp_valid) begin
        busy_q <= 1'b0;
      end
      if (glb_req_valid && glb_req_ready) out_q <= 1'b1;
      else if (glb_rsp_valid)             out_q <= 1'b0;
    end
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (core_req_ready && !core_rsp_valid && !glb_req_valid));

  // R10
  glb_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (glb_req_valid && !glb_req_ready) |=>
      (glb_req_valid && $stable(glb_req_op) && $stable(glb_req_addr) && $stable(glb_req_wdata)));

  // R10
  one_outstanding_chk: assert property (@(posedge clk) disable iff (rst)
    glb_req_valid |-> !out_q);

  // R11
  core_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !core_rsp_valid) |-> !core_req_ready);

  // R6
  atomic_fwd_chk: assert property (@(posedge clk) disable iff (rst)
    (glb_req_valid && glb_req_op == 2'd2) |->
      (busy_q && pend_op == 3'd2 && glb_req_addr == pend_addr && glb_req_wdata == pend_wdata));

  // R4
  glb_load_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (glb_req_valid && busy_q && pend_glob && pend_op == 3'd0 && glb_req_op == 2'd0) |->
      (glb_req_addr == pend_addr));

  // R7
  flush_clean_chk: assert property (@(posedge clk) disable iff (rst)
    (core_rsp_valid && busy_q && pend_op == 3'd3) |-> !any_dirty);

  // R9
  inval_err_chk: assert property (@(posedge clk) disable iff (rst)
    (core_rsp_valid && busy_q && pend_op == 3'd4) |-> (core_rsp_err == any_dirty));
endmodule

bind l1nc_cache l1nc_cache_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk, .rst,
  .core_req_valid, .core_req_ready, .core_req_op, .core_req_global,
  .core_req_addr, .core_req_wdata,
  .core_rsp_valid, .core_rsp_err,
  .glb_req_valid, .glb_req_ready, .glb_req_op, .glb_req_addr, .glb_req_wdata,
  .glb_rsp_valid,
  .any_dirty(ts_any_dirty)
);

// File: tb/l1nc_cache_tb.sv
module l1nc_cache_tb;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int NVEC   = 24;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              core_req_valid = 1'b0;
  logic              core_req_ready;
  logic [2:0]        core_req_op = '0;
  logic              core_req_global = 1'b0;
  logic [ADDR_W-1:0] core_req_addr = '0;
  logic [DATA_W-1:0] core_req_wdata = '0;
  logic              core_rsp_valid;
  logic [DATA_W-1:0] core_rsp_rdata;
  logic              core_rsp_err;
  logic              glb_req_valid;
  logic              glb_req_ready = 1'b0;
  logic [1:0]        glb_req_op;
  logic [ADDR_W-1:0] glb_req_addr;
  logic [DATA_W-1:0] glb_req_wdata;
  logic              glb_rsp_valid = 1'b0;
  logic [DATA_W-1:0] glb_rsp_rdata = '0;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int n_rd = 0, n_wr = 0, n_at = 0;
  int stall_viol = 0, hold_viol = 0;
  logic [DATA_W-1:0] gmem [1024];

  always #10 clk = ~clk;

  l1nc_cache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (.*);

  // global memory model: ready gaps, response one cycle after acceptance
  always @(posedge clk) begin
    cyc <= cyc + 1;
    glb_rsp_valid <= 1'b0;
    glb_req_ready <= (cyc % 3) != 2;
    if (cyc == 0) begin
      for (int i = 0; i < 1024; i++) gmem[i] <= 32'h1000 + i;
    end else if (glb_req_valid && glb_req_ready) begin
      glb_rsp_valid <= 1'b1;
      case (glb_req_op)
        2'd0: begin glb_rsp_rdata <= gmem[glb_req_addr[9:0]]; n_rd <= n_rd + 1; end
        2'd1: begin gmem[glb_req_addr[9:0]] <= glb_req_wdata; glb_rsp_rdata <= '0; n_wr <= n_wr + 1; end
        default: begin
          glb_rsp_rdata <= gmem[glb_req_addr[9:0]];
          gmem[glb_req_addr[9:0]] <= gmem[glb_req_addr[9:0]] + glb_req_wdata;
          n_at <= n_at + 1;
        end
      endcase
    end
  end

  // R10 monitor: a stalled global request must hold its fields
  logic              prev_stall = 1'b0;
  logic [1:0]        prev_op;
  logic [ADDR_W-1:0] prev_a;
  logic [DATA_W-1:0] prev_d;
  always @(negedge clk) begin
    if (!rst && prev_stall &&
        (!glb_req_valid || glb_req_op != prev_op || glb_req_addr != prev_a || glb_req_wdata != prev_d))
      hold_viol++;
    prev_stall = !rst && glb_req_valid && !glb_req_ready;
    prev_op = glb_req_op; prev_a = glb_req_addr; prev_d = glb_req_wdata;
  end

  typedef struct packed {
    logic [2:0]  op;
    logic        glob;
    logic [15:0] addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic        err;
    logic [3:0]  nrd;
    logic [3:0]  nwr;
    logic [3:0]  nat;
  } vec_t;

  // op: 0 load 1 store 2 atomic 3 flush 4 invalidate; global word memory starts at 0x1000+addr
  localparam vec_t VEC [NVEC] = '{
    '{3'd0, 1'b0, 16'h0005, 32'h0,        32'h00001005, 1'b0, 4'd4, 4'd0, 4'd0},
    '{3'd0, 1'b0, 16'h0006, 32'h0,        32'h00001006, 1'b0, 4'd0, 4'd0, 4'd0},
    '{3'd1, 1'b0, 16'h0006, 32'hAAAA0006, 32'h0,        1'b0, 4'd0, 4'd0, 4'd0},
    '{3'd0, 1'b0, 16'h0006, 32'h0,        32'hAAAA0006, 1'b0, 4'd0, 4'd0, 4'd0},
    '{3'd0, 1'b1, 16'h0006, 32'h0,        32'hAAAA0006, 1'b0, 4'd1, 4'd4, 4'd0},
    '{3'd0, 1'b1, 16'h0006, 32'h0,        32'hAAAA0006, 1'b0, 4'd1, 4'd0, 4'd0},
    '{3'd1, 1'b1, 16'h0005, 32'hBBBB0005, 32'h0,        1'b0, 4'd0, 4'd1, 4'd0},
    '{3'd0, 1'b0, 16'h0005, 32'h0,        32'hBBBB0005, 1'b0, 4'd4, 4'd0, 4'd0},
    '{3'd1, 1'b0, 16'h0045, 32'hCCCC0045, 32'h0,        1'b0, 4'd4, 4'd0, 4'd0},
    '{3'd0, 1'b0, 16'h0085, 32'h0,        32'h00001085, 1'b0, 4'd4, 4'd4, 4'd0},
    '{3'd0, 1'b1, 16'h0045, 32'h0,        32'hCCCC0045, 1'b0, 4'd1, 4'd0, 4'd0},
    '{3'd2, 1'b0, 16'h0100, 32'h5,        32'h00001100, 1'b0, 4'd0, 4'd0, 4'd1},
    '{3'd1, 1'b0, 16'h0087, 32'hDDDD0087, 32'h0,        1'b0, 4'd0, 4'd0, 4'd0},
    '{3'd2, 1'b0, 16'h0087, 32'h1,        32'hDDDD0087, 1'b0, 4'd0, 4'd4, 4'd1},
    '{3'd0, 1'b0, 16'h0087, 32'h0,        32'hDDDD0088, 1'b0, 4'd4, 4'd0, 4'd0},
    '{3'd1, 1'b0, 16'h0009, 32'h11110009, 32'h0,        1'b0, 4'd4, 4'd0, 4'd0},
    '{3'd1, 1'b0, 16'h00C1, 32'h222200C1, 32'h0,        1'b0, 4'd4, 4'd0, 4'd0},
    '{3'd4, 1'b0, 16'h0000, 32'h0,        32'h0,        1'b1, 4'd0, 4'd0, 4'd0},
    '{3'd0, 1'b0, 16'h0009, 32'h0,        32'h11110009, 1'b0, 4'd0, 4'd0, 4'd0},
    '{3'd3, 1'b0, 16'h0000, 32'h0,        32'h0,        1'b0, 4'd0, 4'd8, 4'd0},
    '{3'd3, 1'b0, 16'h0000, 32'h0,        32'h0,        1'b0, 4'd0, 4'd0, 4'd0},
    '{3'd4, 1'b0, 16'h0000, 32'h0,        32'h0,        1'b0, 4'd0, 4'd0, 4'd0},
    '{3'd0, 1'b0, 16'h0009, 32'h0,        32'h11110009, 1'b0, 4'd4, 4'd0, 4'd0},
    '{3'd0, 1'b0, 16'h00C1, 32'h0,        32'h222200C1, 1'b0, 4'd4, 4'd0, 4'd0}
  };

  function automatic string row_req(input int i);
    case (i)
      0, 1:                    return "R2";
      2, 3, 8, 9, 12, 15, 16:  return "R3";
      4, 5, 10:                return "R4";
      6, 7:                    return "R5";
      11, 13, 14:              return "R6";
      17, 18:                  return "R9";
      19, 20, 23:              return "R7";
      default:                 return "R8";
    endcase
  endfunction

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic run_op(input logic [2:0] op, input logic glob, input logic [15:0] addr,
                        input logic [31:0] wd, output logic [31:0] rd, output logic er,
                        output int drd, output int dwr, output int dat);
    int b_rd, b_wr, b_at, t;
    @(negedge clk);
    core_req_valid = 1'b1; core_req_op = op; core_req_global = glob;
    core_req_addr = addr; core_req_wdata = wd;
    while (!core_req_ready) @(negedge clk);
    b_rd = n_rd; b_wr = n_wr; b_at = n_at;
    @(negedge clk);
    core_req_valid = 1'b0;
    t = 0;
    while (!core_rsp_valid && t < 1000) begin
      if (core_req_ready) stall_viol++;
      @(negedge clk);
      t++;
    end
    if (t >= 1000) begin
      errors++;
      $display("FAIL R11 no response: op %0d addr %h", op, addr);
    end
    rd = core_rsp_rdata; er = core_rsp_err;
    drd = n_rd - b_rd; dwr = n_wr - b_wr; dat = n_at - b_at;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R11 watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] rd;
    logic er;
    int drd, dwr, dat;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: idle state after reset
    checks++;
    if (core_req_ready !== 1'b1 || core_rsp_valid !== 1'b0 || glb_req_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: ready %b rsp %b greq %b exp 1 0 0",
               core_req_ready, core_rsp_valid, glb_req_valid);
    end

    for (int i = 0; i < NVEC; i++) begin
      run_op(VEC[i].op, VEC[i].glob, VEC[i].addr, VEC[i].wdata, rd, er, drd, dwr, dat);
      checks++;
      if (rd !== VEC[i].rdata || er !== VEC[i].err || drd != int'(VEC[i].nrd) ||
          dwr != int'(VEC[i].nwr) || dat != int'(VEC[i].nat)) begin
        errors++;
        $display("FAIL %s row %0d: data %h err %b rd %0d wr %0d at %0d exp %h %b %0d %0d %0d",
                 row_req(i), i, rd, er, drd, dwr, dat,
                 VEC[i].rdata, VEC[i].err, VEC[i].nrd, VEC[i].nwr, VEC[i].nat);
      end
    end

    // R7: flushed data landed in global memory
    checks++;
    if (gmem[10'h0C1] !== 32'h222200C1 || gmem[10'h009] !== 32'h11110009) begin
      errors++;
      $display("FAIL R7 global memory: %h %h exp 222200c1 11110009", gmem[10'h0C1], gmem[10'h009]);
    end

    // R10: stalled global requests never changed
    checks++;
    if (hold_viol != 0) begin
      errors++;
      $display("FAIL R10 hold violations %0d exp 0", hold_viol);
    end

    // R11: core ready stayed low while a request was in flight
    checks++;
    if (stall_viol != 0) begin
      errors++;
      $display("FAIL R11 stall violations %0d exp 0", stall_viol);
    end

    // R1: reset again with valid lines present, then check a miss
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (core_req_ready !== 1'b1 || core_rsp_valid !== 1'b0 || glb_req_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1 second reset: ready %b rsp %b greq %b exp 1 0 0",
               core_req_ready, core_rsp_valid, glb_req_valid);
    end
    run_op(3'd0, 1'b0, 16'h0009, 32'h0, rd, er, drd, dwr, dat);
    checks++;
    if (rd !== 32'h11110009 || drd != 4 || dwr != 0) begin
      errors++;
      $display("FAIL R1 load after reset: data %h rd %0d wr %0d exp 11110009 4 0", rd, drd, dwr);
    end

    summary();
  end
endmodule